// File: doc/BRIEF.md
# Gated-Write Board Control Registers

This block is a small register file for a board-management logic device. A processor reaches it over a byte-wide bus. Each access is a single-cycle strobe qualified by a chip select. The block holds three byte registers on word-aligned offsets:

- **Version** (offset 0x0): read-only, a fixed design revision.
- **Status** (offset 0x4): read-only, a synchronized copy of external input lines.
- **Control** (offset 0x8): drives two active-low board outputs, a POST indicator and a reset-out line.

Every control flag has a companion gate bit in the written byte. A write changes the flag only when its gate bit is 1. Software can therefore flip one output without a read-modify-write of the other.

Read data is registered. It appears after the clock edge that samples the read strobe and then holds until the next read. Writes to the read-only offsets and all accesses to undecoded offsets leave the block's state unchanged.

Top module: `brd_ctl_regs`

## Requirements
- R1: A read at offset 0x0 returns the `VERSION` parameter in bits [3:0], with bits [7:4] equal to 0.
- R2: A read at offset 0x4 returns the input lines through a two-flop synchronizer. A change on `status_in` is returned by a read strobe sampled on the third rising edge after the change, and not by strobes on the first or second edge.
- R3: While reset is held and right after it is released, `post_led_n` is 0, `reset_out_n` is 1 and `rdata` is 0x00.
- R4: A write at offset 0x8 with data bit 1 set loads data bit 0 into the POST flag, which drives `post_led_n`. With bit 1 clear, the POST flag keeps its value. Writing 0x03 turns the indicator off (`post_led_n`=1).
- R5: A write at offset 0x8 with data bit 7 set loads data bit 6 into the reset-out flag, which drives `reset_out_n`. With bit 7 clear, the reset-out flag keeps its value. Writing 0x80 asserts reset-out (low) and writing 0xC0 releases it.
- R6: A read at offset 0x8 returns the POST flag in bit 0 and the reset-out flag in bit 6. Gate positions 1 and 7 and all other bits read 0.
- R7: Writes at offsets 0x0 and 0x4, and writes at any undecoded offset, change neither output and leave the control read-back unchanged.
- R8: A read at any offset other than 0x0, 0x4 and 0x8 returns 0x00.
- R9: `rdata` updates on the rising edge that samples a read strobe (`cs`=1, `we`=0) and holds its value on every other edge.
- R10: A flag change from a write is visible on its output pin after the same rising edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; qualifies the access strobe |
| we | input | 1 | 1 = write, 0 = read, when cs is 1 |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| status_in | input | STAT_W | Asynchronous status input lines |
| post_led_n | output | 1 | Active-low POST indicator |
| reset_out_n | output | 1 | Active-low reset-out line |

## Verification
Bus stimulus is driven on the falling edge, and each result is sampled on the following falling edge.

- **Writes and reads:** a write is due on its output pins, and a read on `rdata`, one rising edge after the strobe. The bench compares them half a cycle after that edge.
- **Status path:** a held read strobe is sampled on three consecutive falling edges after an input change. The old value is expected twice and the new value on the third.
- **Random accesses:** input changes are followed by two idle cycles before the next read, so the reference model's value is the one due.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned OFF_VER  = 0;
   localparam int unsigned OFF_STAT = 4;
   localparam int unsigned OFF_CTL  = 8;
   localparam int unsigned FLAG_CNT = 2;

   typedef enum logic [1:0] {SEL_NONE, SEL_VER, SEL_STAT, SEL_CTL} sel_e;

   // flag 0 = POST indicator, flag 1 = reset-out
   function automatic int unsigned flag_pos(input int unsigned i);
      return (i == 0) ? 0 : 6;
   endfunction

   function automatic int unsigned gate_pos(input int unsigned i);
      return (i == 0) ? 1 : 7;
   endfunction

   function automatic logic flag_rst(input int unsigned i);
      return (i == 0) ? 1'b0 : 1'b1;
   endfunction
endpackage

// File: rtl/brd_ctl_dec.sv
module brd_ctl_dec
   import brd_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel
);
   always_comb begin
      if (addr == ADDR_W'(OFF_VER))       sel = SEL_VER;
      else if (addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
      else if (addr == ADDR_W'(OFF_CTL))  sel = SEL_CTL;
      else                                sel = SEL_NONE;
   end
endmodule

// File: rtl/brd_ctl_sync.sv
module brd_ctl_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= '0;
         else        pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/brd_ctl_gflag.sv
module brd_ctl_gflag #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic gate,
   input  logic din,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             q <= RST_VAL;
      else if (wr_en && gate) q <= din;
   end
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
   import brd_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned STAT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  VERSION     = 4'h3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [STAT_W-1:0] status_in,
   output logic              post_led_n,
   output logic              reset_out_n
);
   if (ADDR_W < 4) begin : g_chk_addr
      $error("ADDR_W must reach the control offset");
   end
   if (STAT_W < 1 || STAT_W > REG_W) begin : g_chk_stat
      $error("STAT_W must be 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   sel_e                sel;
   logic                wr_ctl;
   logic                rd_en;
   logic [FLAG_CNT-1:0] flag_q;
   logic [STAT_W-1:0]   stat_sync;
   logic [REG_W-1:0]    ctl_view;
   logic [REG_W-1:0]    rd_mux;
   logic [REG_W-1:0]    rdata_q;

   brd_ctl_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .sel  (sel)
   );

   assign wr_ctl = cs && we && (sel == SEL_CTL);
   assign rd_en  = cs && !we;

   for (genvar gi = 0; gi < FLAG_CNT; gi++) begin : g_flag
      brd_ctl_gflag #(.RST_VAL(flag_rst(gi))) u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (wr_ctl),
         .gate  (wdata[gate_pos(gi)]),
         .din   (wdata[flag_pos(gi)]),
         .q     (flag_q[gi])
      );
   end

   brd_ctl_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (status_in),
      .q     (stat_sync)
   );

   always_comb begin
      ctl_view = '0;
      for (int i = 0; i < FLAG_CNT; i++) ctl_view[flag_pos(i)] = flag_q[i];
   end

   always_comb begin
      case (sel)
         SEL_VER:  rd_mux = REG_W'(VERSION);
         SEL_STAT: rd_mux = REG_W'(stat_sync);
         SEL_CTL:  rd_mux = ctl_view;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= rd_mux;
   end

   assign rdata       = rdata_q;
   assign post_led_n  = flag_q[0];
   assign reset_out_n = flag_q[1];
endmodule

// File: rtl/brd_ctl_chk.sv
module brd_ctl_chk #(
   parameter int unsigned ADDR_W  = 4,
   parameter logic [3:0]  VERSION = 4'h3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              post_led_n,
   input logic              reset_out_n
);
   logic ctl_wr, rd_any;
   assign ctl_wr = cs && we && (addr == ADDR_W'(8));
   assign rd_any = cs && !we;

   // R4 R10
   post_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[1]) |=> (post_led_n == $past(wdata[0])));

   // R4 R7
   post_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_wr && wdata[1]) |=> $stable(post_led_n));

   // R5 R10
   rst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[7]) |=> (reset_out_n == $past(wdata[6])));

   // R5 R7
   rst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_wr && wdata[7]) |=> $stable(reset_out_n));

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |=> $stable(rdata));

   // R1
   ver_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && addr == ADDR_W'(0)) |=> (rdata == {4'b0000, VERSION}));

   // R6
   ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && addr == ADDR_W'(8)) |=>
         (rdata == {1'b0, $past(reset_out_n), 5'b00000, $past(post_led_n)}));

   // R8
   undec_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && addr != ADDR_W'(0) && addr != ADDR_W'(4) && addr != ADDR_W'(8))
         |=> (rdata == 8'h00));
endmodule

bind brd_ctl_regs brd_ctl_chk #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs          (cs),
   .we          (we),
   .addr        (addr),
   .wdata       (wdata),
   .rdata       (rdata),
   .post_led_n  (post_led_n),
   .reset_out_n (reset_out_n)
);

// File: tb/sim_brd_ctl_regs.sv
module sim_brd_ctl_regs;
   localparam int unsigned AW  = 4;
   localparam logic [3:0]  VER = 4'h3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic [7:0]    status_in = 8'h00;
   logic          post_led_n;
   logic          reset_out_n;

   int total = 0;
   int bad   = 0;
   logic m_post = 1'b0;
   logic m_rst  = 1'b1;
   logic [7:0] m_stat = 8'h00;

   always #2 clk = ~clk;

   brd_ctl_regs #(.ADDR_W(AW), .STAT_W(8), .SYNC_STAGES(2), .VERSION(VER)) u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .status_in(status_in), .post_led_n(post_led_n),
      .reset_out_n(reset_out_n)
   );

   function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
      case (a)
         AW'(0):  return {4'b0000, VER};
         AW'(4):  return m_stat;
         AW'(8):  return {1'b0, m_rst, 5'b00000, m_post};
         default: return 8'h00;
      endcase
   endfunction

   function automatic string req_of(input logic [AW-1:0] a);
      case (a)
         AW'(0):  return "R1";
         AW'(4):  return "R2";
         AW'(8):  return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic check_pins(input string req);
      check(req, {6'b0, reset_out_n, post_led_n}, {6'b0, m_rst, m_post});
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
      cs = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; we = 1'b0;
      if (a == AW'(8)) begin
         if (d[1]) m_post = d[0];
         if (d[7]) m_rst  = d[6];
      end
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
      cs = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      cs = 1'b0;
      d = rdata;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [7:0] rd;
      logic [7:0] held;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R3 during reset
      check("R3", {6'b0, reset_out_n, post_led_n}, 8'h02);
      check("R3", rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", {6'b0, reset_out_n, post_led_n}, 8'h02);
      check("R3", rdata, 8'h00);

      // R1 version
      bus_rd(AW'(0), rd); check("R1", rd, {4'b0000, VER});
      // R6 control reset readback
      bus_rd(AW'(8), rd); check("R6", rd, 8'h40);
      // R4 turn POST off with 0x03
      bus_wr(AW'(8), 8'h03); check_pins("R4");
      check("R10", {7'b0, post_led_n}, 8'h01);
      // R4 gate clear: no change
      bus_wr(AW'(8), 8'h00); check_pins("R4");
      // R5 assert reset-out with 0x80
      bus_wr(AW'(8), 8'h80); check("R5", {7'b0, reset_out_n}, 8'h00);
      check_pins("R4");
      bus_rd(AW'(8), rd); check("R6", rd, 8'h01);
      // R5 gate clear: bit6 set but ignored
      bus_wr(AW'(8), 8'h41); check("R5", {7'b0, reset_out_n}, 8'h00);
      // R5 release with 0xC0
      bus_wr(AW'(8), 8'hC0); check("R5", {7'b0, reset_out_n}, 8'h01);
      bus_rd(AW'(8), rd); check("R6", rd, 8'h41);
      // R7 writes to read-only and undecoded offsets
      bus_wr(AW'(0), 8'h82); check_pins("R7");
      bus_wr(AW'(4), 8'h82); check_pins("R7");
      bus_wr(AW'(12), 8'h82); check_pins("R7");
      bus_wr(AW'(9), 8'h82); check_pins("R7");
      bus_rd(AW'(8), rd); check("R7", rd, 8'h41);
      // R8 undecoded reads
      bus_rd(AW'(12), rd); check("R8", rd, 8'h00);
      bus_rd(AW'(1), rd);  check("R8", rd, 8'h00);
      // R9 rdata holds with no read
      bus_rd(AW'(0), rd);
      held = rdata;
      bus_wr(AW'(8), 8'h02); check_pins("R4");
      repeat (3) @(negedge clk);
      check("R9", rdata, held);

      // R2 synchronizer latency
      status_in = 8'hA5;
      cs = 1'b1; we = 1'b0; addr = AW'(4);
      @(negedge clk); check("R2", rdata, 8'h00);
      @(negedge clk); check("R2", rdata, 8'h00);
      @(negedge clk); check("R2", rdata, 8'hA5);
      cs = 1'b0;
      m_stat = 8'hA5;

      // random traffic
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] a;
         logic [7:0] d;
         int unsigned pick;
         pick = $urandom_range(0, 9);
         case (pick % 5)
            0: a = AW'(0);
            1: a = AW'(4);
            2, 3: a = AW'(8);
            default: a = AW'($urandom_range(0, 15));
         endcase
         d = 8'($urandom);
         if (pick == 9) begin
            status_in = 8'($urandom);
            repeat (2) @(negedge clk);
            m_stat = status_in;
         end else if ($urandom_range(0, 1) == 1) begin
            bus_wr(a, d);
            check_pins(a == AW'(8) ? "R4" : "R7");
         end else begin
            bus_rd(a, rd);
            check(req_of(a), rd, exp_read(a));
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule